// File: doc/BRIEF.md
# Serial CRC-8 Accumulator with Identity Self-Check

This block computes the 8-bit cyclic check used by a single-wire identification and memory device. The generator is x^8 + x^5 + x^4 + 1, worked in reflected form: the remainder shifts towards its least significant bit and data enters least significant bit first. Memory controllers clear the accumulator and then feed it one bit per strobe, or a whole byte per clock, to build the checksum they return to the bus master. A received check byte can be fed in after its data. The remainder then falls to zero, and a flag shows that zero residue.

The block also holds the device's 64-bit identity code. The family byte sits in the low byte and the serial number above it. The top byte is a check byte computed from those 56 bits. After reset, a separate walker shifts all 64 identity bits, one per clock, through its own remainder. It raises a good-identity flag once the residue is found to be zero.

Top module: `crc8_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it, `crc_o` is 8'h00 and `zero_ok_o` is 1.
- R2: A bit strobe updates the remainder on the next clock edge. The feedback is `crc_o[0]` XOR `bit_i`. The remainder shifts right by one, and it is XORed with 8'h8C when the feedback is 1.
- R3: A byte strobe updates the remainder in one clock. The result equals eight bit steps, applied in order from `byte_i[0]` to `byte_i[7]`.
- R4: A clear in the same cycle as any bit or byte strobe wins. The remainder becomes 8'h00 and the strobed data is discarded.
- R5: When the bit and byte strobes come in the same cycle without a clear, the single bit is applied first and the byte after it. The update is nine bits in one clock.
- R6: With no strobe and no clear, the remainder holds its value.
- R7: `zero_ok_o` is 1 exactly when `crc_o` is 8'h00. Feeding a message and then its own remainder (least significant bit first) brings the flag to 1.
- R8: `id_code_o[7:0]` is the family parameter (default 8'h09), and `id_code_o[55:8]` is the serial parameter. `id_code_o[63:56]` is the remainder after the 56 bits `id_code_o[55:0]`, fed from bit 0 upward, starting from 8'h00.
- R9: `id_ok_o` is 0 until 64 clock edges after reset is released, and 1 from the 64th edge on. This holds when the identity code has a zero residue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Clear remainder to zero |
| bit_vld_i | input | 1 | Bit strobe |
| bit_i | input | 1 | Serial data bit |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Byte data, bit 0 enters first |
| crc_o | output | 8 | Current remainder |
| zero_ok_o | output | 1 | Remainder is zero |
| id_code_o | output | 64 | Identity code: check, serial, family |
| id_ok_o | output | 1 | Identity self-check finished with zero residue |

## Verification
The bench builds the block with its default family value 8'h09 and a fixed 48-bit serial. This keeps the 64-edge self-check window short enough to test at both of its boundary edges. Because the data width is 8, all 256 byte values can be swept through the byte port from several starting remainders. Each result is compared with a model written in the non-reflected, most-significant-bit-first form, which is arithmetically equal. The same sweep also covers the bit port, the clear and combined-strobe priorities, and the zero-residue round trip.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
    localparam int CRC_W  = 8;
    localparam int FAM_W  = 8;
    localparam int SER_W  = 48;
    localparam int ID_W   = CRC_W + SER_W + FAM_W;
    localparam int BODY_W = SER_W + FAM_W;
    localparam logic [CRC_W-1:0] POLY_REFL = 8'h8C;

    typedef logic [CRC_W-1:0] crc_t;

    typedef struct packed {
        logic [CRC_W-1:0] check;
        logic [SER_W-1:0] serial;
        logic [FAM_W-1:0] family;
    } id_code_t;

    function automatic crc_t crc_step(input crc_t c, input logic d);
        logic fb;
        fb = c[0] ^ d;
        crc_step = (c >> 1) ^ (fb ? POLY_REFL : '0);
    endfunction

    function automatic crc_t crc_body(input logic [BODY_W-1:0] v);
        crc_t c;
        c = '0;
        for (int i = 0; i < BODY_W; i++) c = crc_step(c, v[i]);
        crc_body = c;
    endfunction
endpackage

// File: rtl/crc8_byte_upd.sv
module crc8_byte_upd
    import crc8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  crc_t              crc_i,
    input  logic [DATA_W-1:0] data_i,
    output crc_t              crc_o
);
    crc_t stage [DATA_W+1];

    assign stage[0] = crc_i;

    for (genvar g = 0; g < DATA_W; g++) begin : g_chain
        assign stage[g+1] = crc_step(stage[g], data_i[g]);
    end

    assign crc_o = stage[DATA_W];
endmodule

// File: rtl/crc8_accum.sv
module crc8_accum
    import crc8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    input  logic              byte_vld_i,
    input  logic [DATA_W-1:0] byte_i,
    output crc_t              crc_o
);
    crc_t crc_q;
    crc_t after_bit;
    crc_t after_byte;
    crc_t crc_d;

    assign after_bit = bit_vld_i ? crc_step(crc_q, bit_i) : crc_q;

    crc8_byte_upd #(.DATA_W(DATA_W)) u_byte (
        .crc_i  (after_bit),
        .data_i (byte_i),
        .crc_o  (after_byte)
    );

    always_comb begin
        if (clr_i)           crc_d = '0;
        else if (byte_vld_i) crc_d = after_byte;
        else                 crc_d = after_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) crc_q <= '0;
        else     crc_q <= crc_d;
    end

    assign crc_o = crc_q;

    p_clear_wins_r4: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (crc_q == '0));

    p_idle_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !bit_vld_i && !byte_vld_i) |=> $stable(crc_q));
endmodule

// File: rtl/crc8_id_selfcheck.sv
module crc8_id_selfcheck
    import crc8_pkg::*;
#(
    parameter int CODE_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_i,
    output logic              ok_o
);
    localparam int IDX_W = $clog2(CODE_W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(CODE_W - 1);

    logic [IDX_W-1:0] idx_q;
    logic             done_q;
    crc_t             walk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            done_q <= 1'b0;
            walk_q <= '0;
        end else if (!done_q) begin
            walk_q <= crc_step(walk_q, code_i[idx_q]);
            idx_q  <= idx_q + IDX_W'(1);
            if (idx_q == LAST) done_q <= 1'b1;
        end
    end

    assign ok_o = done_q && (walk_q == '0);

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> done_q);

    p_walk_advances_r9: assert property (@(posedge clk) disable iff (rst)
        (!done_q && idx_q != LAST) |=> (idx_q == $past(idx_q) + IDX_W'(1)) && !done_q);
endmodule

// File: rtl/crc8_unit.sv
module crc8_unit
    import crc8_pkg::*;
#(
    parameter logic [FAM_W-1:0] FAMILY = 8'h09,
    parameter logic [SER_W-1:0] SERIAL = 48'h0000_5A3C_91E7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_i,
    input  logic            bit_vld_i,
    input  logic            bit_i,
    input  logic            byte_vld_i,
    input  logic [7:0]      byte_i,
    output logic [7:0]      crc_o,
    output logic            zero_ok_o,
    output logic [ID_W-1:0] id_code_o,
    output logic            id_ok_o
);
    id_code_t id_w;
    crc_t     crc_w;

    always_comb begin
        id_w.family = FAMILY;
        id_w.serial = SERIAL;
        id_w.check  = crc_body({SERIAL, FAMILY});
    end

    crc8_accum #(.DATA_W(8)) u_accum (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (clr_i),
        .bit_vld_i  (bit_vld_i),
        .bit_i      (bit_i),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .crc_o      (crc_w)
    );

    crc8_id_selfcheck #(.CODE_W(ID_W)) u_check (
        .clk    (clk),
        .rst    (rst),
        .code_i (id_w),
        .ok_o   (id_ok_o)
    );

    assign crc_o     = crc_w;
    assign zero_ok_o = (crc_w == '0);
    assign id_code_o = id_w;

    p_clear_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> zero_ok_o);
endmodule

// File: tb/tb_crc8_unit.sv
module tb_crc8_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0, byte_vld_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic [7:0]  crc_o;
    logic        zero_ok_o;
    logic [63:0] id_code_o;
    logic        id_ok_o;

    int errors = 0;
    int checks = 0;
    logic [7:0] m;

    localparam logic [47:0] SER = 48'h0000_5A3C_91E7;

    always #4 clk = ~clk;

    crc8_unit dut (.*);

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Model: MSB-first register with unreflected polynomial 0x31, output bit-reversed.
    function automatic logic [7:0] rev8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
    endfunction

    function automatic logic [7:0] mbit(input logic [7:0] c, input logic d);
        logic [7:0] r;
        r = rev8(c);
        if (r[7] ^ d) r = {r[6:0], 1'b0} ^ 8'h31;
        else          r = {r[6:0], 1'b0};
        mbit = rev8(r);
    endfunction

    function automatic logic [7:0] mbyte(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] x;
        x = c;
        for (int i = 0; i < 8; i++) x = mbit(x, b[i]);
        mbyte = x;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic bv, input logic b,
                         input logic yv, input logic [7:0] y);
        clr_i = c; bit_vld_i = bv; bit_i = b; byte_vld_i = yv; byte_i = y;
        @(negedge clk);
        clr_i = 0; bit_vld_i = 0; bit_i = 0; byte_vld_i = 0; byte_i = '0;
    endtask

    initial begin
        logic [7:0] body_crc;
        @(negedge clk); @(negedge clk);
        chk("R1 reset crc", {56'd0, crc_o}, 64'd0);
        chk("R1 reset flag", {63'd0, zero_ok_o}, 64'd1);
        rst = 1'b0;
        // R9 window, R1 post-reset
        for (int e = 1; e <= 63; e++) begin
            @(negedge clk);
            if (e == 1) chk("R1 first cycle crc", {56'd0, crc_o}, 64'd0);
            if (e == 63) chk("R9 id_ok before 64th edge", {63'd0, id_ok_o}, 64'd0);
        end
        @(negedge clk);
        chk("R9 id_ok at 64th edge", {63'd0, id_ok_o}, 64'd1);

        // R8 identity layout
        body_crc = 8'h00;
        for (int i = 0; i < 8; i++) body_crc = mbit(body_crc, id_code_o[i]);
        for (int i = 0; i < 48; i++) body_crc = mbit(body_crc, SER[i]);
        chk("R8 family", {56'd0, id_code_o[7:0]}, 64'h09);
        chk("R8 serial", {16'd0, id_code_o[55:8]}, {16'd0, SER});
        chk("R8 check byte", {56'd0, id_code_o[63:56]}, {56'd0, body_crc});

        // R2 bit port, several patterns
        drive(1, 0, 0, 0, 0); m = 0;
        for (int i = 0; i < 40; i++) begin
            logic d;
            d = ((i * 7 + 3) % 5) < 2;
            drive(0, 1, d, 0, 0);
            m = mbit(m, d);
            chk("R2 bit step", {56'd0, crc_o}, {56'd0, m});
            chk("R7 flag tracks", {63'd0, zero_ok_o}, {63'd0, m == 0});
        end

        // R6 hold
        for (int i = 0; i < 3; i++) begin
            drive(0, 0, 1, 0, 8'hFF);
            chk("R6 idle hold", {56'd0, crc_o}, {56'd0, m});
        end

        // R3 exhaustive byte sweep from several starting remainders
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] pre;
                pre = 8'(s * 77 + 1);
                drive(1, 0, 0, 0, 0);
                drive(0, 0, 0, 1, pre);
                drive(0, 0, 0, 1, 8'(v));
                m = mbyte(mbyte(8'h00, pre), 8'(v));
                chk("R3 byte sweep", {56'd0, crc_o}, {56'd0, m});
            end
        end

        // R3 byte equals eight bit strobes
        drive(1, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) drive(0, 1, (8'hB6 >> i) & 1, 0, 0);
        chk("R3 bits vs byte", {56'd0, crc_o}, {56'd0, mbyte(8'h00, 8'hB6)});

        // R4 clear priority over bit and over byte
        drive(0, 0, 0, 1, 8'h5E);
        drive(1, 1, 1, 0, 0);
        chk("R4 clear beats bit", {56'd0, crc_o}, 64'd0);
        drive(1, 0, 0, 1, 8'hA7);
        chk("R4 clear beats byte", {56'd0, crc_o}, 64'd0);
        drive(0, 1, 1, 0, 0);
        chk("R4 bit after clear counted once", {56'd0, crc_o}, {56'd0, mbit(8'h00, 1'b1)});

        // R5 bit then byte in same cycle
        for (int t = 0; t < 16; t++) begin
            logic [7:0] y;
            y = 8'(t * 29 + 5);
            drive(1, 0, 0, 0, 0);
            drive(0, 1, t[0], 1, y);
            chk("R5 bit then byte", {56'd0, crc_o}, {56'd0, mbyte(mbit(8'h00, t[0]), y)});
        end

        // R7 round trip: message then its own remainder
        for (int t = 0; t < 8; t++) begin
            logic [7:0] rem;
            drive(1, 0, 0, 0, 0);
            rem = 8'h00;
            for (int k = 0; k < 3; k++) begin
                drive(0, 0, 0, 1, 8'(t * 53 + k * 17 + 1));
                rem = mbyte(rem, 8'(t * 53 + k * 17 + 1));
            end
            chk("R7 remainder before check byte", {56'd0, crc_o}, {56'd0, rem});
            drive(0, 0, 0, 1, rem);
            chk("R7 zero residue", {63'd0, zero_ok_o}, 64'd1);
        end

        // R9 flag stays up
        chk("R9 id_ok stays", {63'd0, id_ok_o}, 64'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule